// File: doc/BRIEF.md
# Atomic Access Monitor for a Shared Memory Target

This unit sits between the request stream of several initiators and a single shared memory. Each request carries a command, a word address, write data, a burst length and the identifier of the initiator's connection. The unit passes ordinary reads and writes through to the memory. It also provides two kinds of synchronization between initiators.

The first kind is a blocking lock. An exclusive read takes ownership of the target for the requesting connection. Requests from every other connection then stall until the owner issues a single write that releases the lock. The second kind is a lazy reservation. A linked read records a reservation for its connection at the word it read. A later conditional write from that connection is performed only if the reservation is still intact. Any committed write to a reserved word breaks every reservation on that word.

Each accepted request gets one response a cycle later, carrying a code and, for reads, the memory data. Atomic commands inside a multi-transfer burst are rejected with an error response and do not touch the memory.

Top module: `atomic_access_monitor`

## Requirements
- R1: An accepted command 3 (exclusive read) with burst length 1 reads the memory. It answers with code 1 (DVA) and the data. It sets the lock with the requesting connection ID as owner.
- R2: While the lock is set, `cmd_accept` is low for a valid request whose connection ID differs from the owner's. Requests from the owner, and every request while no lock is set, are accepted in the same cycle as `req_valid`.
- R3: While the lock is set, an accepted write command (1, 5 or 7) with burst length 1 from the owner is written to memory, answered with code 1 and clears the lock.
- R4: Commands 3, 4 and 6 with a burst length other than 1 are answered with code 3 (ERR). So is the owner's write with such a length while the lock is set. None of these accesses the memory, and none changes the lock or the reservations.
- R5: An accepted command 4 (linked read) with burst length 1 reads the memory and answers with code 1 and the data. It sets the reservation of its connection to its address, replacing any earlier one.
- R6: A command 6 (conditional write) with burst length 1 whose connection holds a valid reservation at the same address writes the memory and answers with code 1.
- R7: A command 6 with burst length 1 without such a reservation does not write the memory and answers with code 2 (FAIL).
- R8: Any committed write, whether plain or conditional, clears the reservations of every connection at that address. Reservations at other addresses stay valid.
- R9: The response arrives the cycle after acceptance. Command 2 (read) gives code 1 with the memory data. Plain writes give code 1. Command 0 (idle) gives no response. `rsp_data` is zero except on read responses. Memory read data is taken one cycle after `mem_rd`.
- R10: After reset there is no lock, no reservation and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_cmd | input | 3 | Command code (0 idle, 1 write, 2 read, 3 exclusive read, 4 linked read, 5 non-posted write, 6 conditional write, 7 broadcast write) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_conn | input | CONN_W | Connection ID of the initiator |
| req_blen | input | BLEN_W | Burst length of the request |
| cmd_accept | output | 1 | Request is taken this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 none, 1 DVA, 2 FAIL, 3 ERR |
| rsp_data | output | DATA_W | Read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_rd` |

## Verification
The bench builds the unit with its defaults: four connection IDs, an 8-bit address, 16-bit data and a 3-bit burst length. Random addresses are confined to four words. With that confinement, linked reads from different connections often land on the same word, and writes from others often break them. Random burst lengths of 2 bring the error path within reach for every atomic command and for the owner's unlocking write. Four connections are enough for blocked and unblocked initiators to exist at the same time while a lock is held.

// File: rtl/atm_pkg.sv
// Shared command and response codes for the atomic access monitor.
// Assumes a 3-bit command and a 2-bit response code at the block edge.
package atm_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE = 3'd0,
        CMD_WR   = 3'd1,
        CMD_RD   = 3'd2,
        CMD_RDEX = 3'd3,
        CMD_RDLK = 3'd4,
        CMD_WRNP = 3'd5,
        CMD_WRC  = 3'd6,
        CMD_BCST = 3'd7
    } atm_cmd_e;

    typedef enum logic [1:0] {
        RSP_NULL = 2'd0,
        RSP_DVA  = 2'd1,
        RSP_FAIL = 2'd2,
        RSP_ERR  = 2'd3
    } atm_rsp_e;

    // True for the commands that write unconditionally.
    function automatic logic is_plain_write(input logic [2:0] c);
        return (c == CMD_WR) || (c == CMD_WRNP) || (c == CMD_BCST);
    endfunction

    // True for the commands barred from bursts.
    function automatic logic is_atomic(input logic [2:0] c);
        return (c == CMD_RDEX) || (c == CMD_RDLK) || (c == CMD_WRC);
    endfunction

endpackage

// File: rtl/atm_lock_ctrl.sv
// Lock owner register and request admission.
// Holds one blocking lock; while it is held only the owning connection
// is admitted. Assumes set and clear are never requested together.
module atm_lock_ctrl #(
    parameter int CONN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CONN_W-1:0] req_conn,
    input  logic              set_lock,
    input  logic              clr_lock,
    output logic              accept,
    output logic              lock_held,
    output logic [CONN_W-1:0] lock_owner
);

    // Admit unless another connection owns the lock.
    always_comb begin
        accept = req_valid && (!lock_held || (req_conn == lock_owner));
    end

    // Take or release the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_held  <= 1'b0;
            lock_owner <= '0;
        end else if (set_lock) begin
            lock_held  <= 1'b1;
            lock_owner <= req_conn;
        end else if (clr_lock) begin
            lock_held  <= 1'b0;
        end
    end

endmodule

// File: rtl/atm_resv_table.sv
// One reservation slot per connection ID: a valid bit and a word address.
// A linked read loads its own slot; a committed write to an address
// clears every slot holding that address. Assumes load and commit are
// never asserted in the same cycle.
module atm_resv_table #(
    parameter int CONN_W = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CONN_W-1:0] req_conn,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              set_resv,
    input  logic              wr_commit,
    output logic              hit
);

    localparam int NCONN = 1 << CONN_W;

    logic [NCONN-1:0]  slot_v;
    logic [ADDR_W-1:0] slot_a [NCONN];

    for (genvar i = 0; i < NCONN; i++) begin : g_slot
        logic              v_q;
        logic [ADDR_W-1:0] a_q;

        // Load on own linked read, drop on a write to the held word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                a_q <= '0;
            end else if (set_resv && (req_conn == CONN_W'(i))) begin
                v_q <= 1'b1;
                a_q <= req_addr;
            end else if (wr_commit && v_q && (a_q == req_addr)) begin
                v_q <= 1'b0;
            end
        end

        assign slot_v[i] = v_q;
        assign slot_a[i] = a_q;
    end

    // Requesting connection holds a reservation at the requested word.
    always_comb begin
        hit = slot_v[req_conn] && (slot_a[req_conn] == req_addr);
    end

endmodule

// File: rtl/atm_decode.sv
// Command classification for an admitted request. Purely combinational:
// decides memory access, lock and reservation updates and response code.
// Assumes only the owner can be admitted while the lock is held.
module atm_decode #(
    parameter int BLEN_W = 3
) (
    input  logic              fire,
    input  logic [2:0]        cmd,
    input  logic [BLEN_W-1:0] blen,
    input  logic              lock_held,
    input  logic              resv_hit,
    output logic              do_rd,
    output logic              do_wr,
    output logic              set_lock,
    output logic              clr_lock,
    output logic              set_resv,
    output logic [1:0]        rsp_code
);
    import atm_pkg::*;

    logic single, pw, err, wr_plain, wc_ok;

    // Classify the request and derive every side effect.
    always_comb begin
        single   = (blen == BLEN_W'(1));
        pw       = is_plain_write(cmd);
        err      = (is_atomic(cmd) && !single) || (pw && lock_held && !single);
        wr_plain = fire && !err && pw;
        wc_ok    = fire && (cmd == CMD_WRC) && single && resv_hit;
        do_rd    = fire && !err &&
                   ((cmd == CMD_RD) || (cmd == CMD_RDEX) || (cmd == CMD_RDLK));
        do_wr    = wr_plain || wc_ok;
        set_lock = fire && (cmd == CMD_RDEX) && single;
        clr_lock = wr_plain && lock_held;
        set_resv = fire && (cmd == CMD_RDLK) && single;
        if (!fire || (cmd == CMD_IDLE))  rsp_code = RSP_NULL;
        else if (err)                    rsp_code = RSP_ERR;
        else if ((cmd == CMD_WRC) && !resv_hit) rsp_code = RSP_FAIL;
        else                             rsp_code = RSP_DVA;
    end

endmodule

// File: rtl/atomic_access_monitor.sv
// Atomic access monitor in front of a shared memory target.
// Provides a blocking lock (exclusive read then unlocking write) and
// per-connection reservations (linked read then conditional write).
// Assumes the memory writes on the clock edge of mem_wr and returns read
// data one cycle after mem_rd; responses are never back-pressured.
module atomic_access_monitor #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CONN_W = 2,
    parameter int BLEN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CONN_W-1:0] req_conn,
    input  logic [BLEN_W-1:0] req_blen,
    output logic              cmd_accept,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import atm_pkg::*;

    logic              lock_held;
    logic [CONN_W-1:0] lock_owner;
    logic              set_lock, clr_lock, set_resv, resv_hit;
    logic              do_rd, do_wr;
    logic [1:0]        code_d;
    logic              rd_pend;

    atm_lock_ctrl #(.CONN_W(CONN_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_conn   (req_conn),
        .set_lock   (set_lock),
        .clr_lock   (clr_lock),
        .accept     (cmd_accept),
        .lock_held  (lock_held),
        .lock_owner (lock_owner)
    );

    atm_resv_table #(.CONN_W(CONN_W), .ADDR_W(ADDR_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_conn  (req_conn),
        .req_addr  (req_addr),
        .set_resv  (set_resv),
        .wr_commit (do_wr),
        .hit       (resv_hit)
    );

    atm_decode #(.BLEN_W(BLEN_W)) u_dec (
        .fire      (cmd_accept),
        .cmd       (req_cmd),
        .blen      (req_blen),
        .lock_held (lock_held),
        .resv_hit  (resv_hit),
        .do_rd     (do_rd),
        .do_wr     (do_wr),
        .set_lock  (set_lock),
        .clr_lock  (clr_lock),
        .set_resv  (set_resv),
        .rsp_code  (code_d)
    );

    // Memory side follows the admitted request directly.
    always_comb begin
        mem_wr    = do_wr;
        mem_rd    = do_rd;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
    end

    // Register the response one cycle after admission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_NULL;
            rd_pend   <= 1'b0;
        end else begin
            rsp_valid <= (code_d != RSP_NULL);
            rsp_code  <= code_d;
            rd_pend   <= do_rd;
        end
    end

    // Read data is forwarded only on read responses.
    always_comb begin
        rsp_data = rd_pend ? mem_rdata : '0;
    end

endmodule

// File: rtl/atomic_access_monitor_chk.sv
// Property checker for the atomic access monitor, bound to the top.
module atomic_access_monitor_chk #(
    parameter int ADDR_W = 8,
    parameter int CONN_W = 2,
    parameter int BLEN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_cmd,
    input logic [CONN_W-1:0] req_conn,
    input logic [BLEN_W-1:0] req_blen,
    input logic              cmd_accept,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              lock_held,
    input logic [CONN_W-1:0] lock_owner
);
    import atm_pkg::*;

    // R2: a foreign connection is never admitted while locked
    a_r2_block_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lock_held && (req_conn != lock_owner)) |-> !cmd_accept);

    // R1: exclusive read of length 1 leaves the requester owning the lock
    a_r1_lock_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && (req_cmd == CMD_RDEX) && (req_blen == BLEN_W'(1)))
        |=> (lock_held && (lock_owner == $past(req_conn))));

    // R4: atomic command inside a burst is answered with ERR
    a_r4_burst_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && is_atomic(req_cmd) && (req_blen != BLEN_W'(1)))
        |=> (rsp_valid && (rsp_code == RSP_ERR)));

    // R4: rejected burst makes no memory access
    a_r4_no_mem_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && is_atomic(req_cmd) && (req_blen != BLEN_W'(1)))
        |-> (!mem_wr && !mem_rd));

    // R7: a FAIL response follows a cycle without a memory write
    a_r7_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == RSP_FAIL)) |-> $past(!mem_wr));

    // R9: every admitted non-idle command gets a response next cycle
    a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && (req_cmd != CMD_IDLE)) |=> rsp_valid);

    // R9: no response without a preceding admitted request
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_accept));

endmodule

bind atomic_access_monitor atomic_access_monitor_chk #(
    .ADDR_W(ADDR_W), .CONN_W(CONN_W), .BLEN_W(BLEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .req_conn   (req_conn),
    .req_blen   (req_blen),
    .cmd_accept (cmd_accept),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .lock_held  (lock_held),
    .lock_owner (lock_owner)
);

// File: tb/atomic_access_monitor_bench.sv
// Bench: directed lock and reservation cases, then seeded random traffic,
// checked against a reference model kept in the bench.
module atomic_access_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int CONN_W = 2;
    localparam int BLEN_W = 3;
    localparam int NCONN  = 1 << CONN_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [CONN_W-1:0] req_conn = '0;
    logic [BLEN_W-1:0] req_blen = '0;
    logic              cmd_accept, rsp_valid, mem_wr, mem_rd;
    logic [1:0]        rsp_code;
    logic [DATA_W-1:0] rsp_data, mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [ADDR_W-1:0] mem_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // Slave memory and reference model state.
    logic [DATA_W-1:0] mem     [DEPTH];
    logic [DATA_W-1:0] ref_mem [DEPTH];
    logic              ref_lock;
    logic [CONN_W-1:0] ref_owner;
    logic              ref_rv [NCONN];
    logic [ADDR_W-1:0] ref_ra [NCONN];

    atomic_access_monitor #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONN_W(CONN_W), .BLEN_W(BLEN_W)
    ) u_atomic_access_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_conn(req_conn),
        .req_blen(req_blen), .cmd_accept(cmd_accept), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_data(rsp_data), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory slave: write on the edge, read data one cycle later.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem_rd ? mem[mem_addr] : '0;
    end

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic is_pw(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd5) || (c == 3'd7);
    endfunction

    function automatic logic is_at(input logic [2:0] c);
        return (c == 3'd3) || (c == 3'd4) || (c == 3'd6);
    endfunction

    // Reference: clear every reservation at a written word.
    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        ref_mem[a] = d;
        for (int i = 0; i < NCONN; i++)
            if (ref_rv[i] && ref_ra[i] == a) ref_rv[i] = 1'b0;
    endtask

    // One request: check admission, update model, check the response.
    task automatic txn(input logic [CONN_W-1:0] c, input logic [2:0] cmd,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic [BLEN_W-1:0] bl);
        logic       acc, single, err;
        logic [1:0] ecode;
        logic [DATA_W-1:0] edata;
        string      tag;
        @(negedge clk);
        req_valid = 1'b1; req_conn = c; req_cmd = cmd;
        req_addr = a; req_wdata = d; req_blen = bl;
        #1;
        acc = !(ref_lock && c != ref_owner);
        check("R2 admission", {31'd0, cmd_accept}, {31'd0, acc});
        single = (bl == BLEN_W'(1));
        err = (is_at(cmd) && !single) || (is_pw(cmd) && ref_lock && !single);
        ecode = 2'd0; edata = '0; tag = "R9 read/idle";
        if (acc && cmd != 3'd0) begin
            if (err) begin
                ecode = 2'd3; tag = "R4 burst reject";
            end else if (cmd == 3'd2 || cmd == 3'd3 || cmd == 3'd4) begin
                ecode = 2'd1; edata = ref_mem[a];
                if (cmd == 3'd3) begin
                    ref_lock = 1'b1; ref_owner = c; tag = "R1 exclusive read";
                end else if (cmd == 3'd4) begin
                    ref_rv[c] = 1'b1; ref_ra[c] = a; tag = "R5 linked read";
                end
            end else if (is_pw(cmd)) begin
                ecode = 2'd1;
                tag = ref_lock ? "R3 unlocking write" : "R8 plain write";
                ref_lock = 1'b0;
                model_write(a, d);
            end else begin
                if (ref_rv[c] && ref_ra[c] == a) begin
                    ecode = 2'd1; tag = "R6 conditional ok";
                    model_write(a, d);
                end else begin
                    ecode = 2'd2; tag = "R7 conditional fail";
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {31'd0, rsp_valid}, {31'd0, (ecode != 2'd0)});
        check({tag, " code"}, {30'd0, rsp_code}, {30'd0, ecode});
        check({tag, " data"}, {16'd0, rsp_data}, {16'd0, edata});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        for (int i = 0; i < NCONN; i++) begin ref_rv[i] = 1'b0; ref_ra[i] = '0; end
        ref_lock = 1'b0; ref_owner = '0;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset, no reservation, no lock
        check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        txn(2'd0, 3'd6, 8'd0, 16'h1111, 3'd1);   // R10 no reservation: FAIL
        txn(2'd3, 3'd2, 8'd0, 16'h0, 3'd1);      // R10 no lock, R7 no write
        txn(2'd1, 3'd1, 8'd5, 16'hA5A5, 3'd1);
        // Lock sequence: R1, R2, R4, R3
        txn(2'd1, 3'd3, 8'd5, 16'h0, 3'd1);
        txn(2'd2, 3'd2, 8'd5, 16'h0, 3'd1);      // blocked
        txn(2'd1, 3'd2, 8'd5, 16'h0, 3'd1);      // owner passes
        txn(2'd1, 3'd5, 8'd5, 16'hBEEF, 3'd2);   // R4 owner burst write rejected
        txn(2'd2, 3'd1, 8'd5, 16'h0, 3'd1);      // still blocked
        txn(2'd1, 3'd5, 8'd5, 16'hBEEF, 3'd1);   // R3 release
        txn(2'd2, 3'd2, 8'd5, 16'h0, 3'd1);      // now admitted, sees BEEF
        // Reservations: R5, R8, R6, R7
        txn(2'd0, 3'd4, 8'd3, 16'h0, 3'd1);
        txn(2'd1, 3'd4, 8'd3, 16'h0, 3'd1);
        txn(2'd2, 3'd4, 8'd4, 16'h0, 3'd1);
        txn(2'd3, 3'd1, 8'd3, 16'h3333, 3'd1);   // R8 breaks 0 and 1
        txn(2'd0, 3'd6, 8'd3, 16'hDEAD, 3'd1);   // R7 fail
        txn(2'd1, 3'd6, 8'd3, 16'hDEAD, 3'd1);   // R7 fail
        txn(2'd2, 3'd6, 8'd4, 16'h4444, 3'd1);   // R6 ok, R8 kept other word
        txn(2'd3, 3'd2, 8'd3, 16'h0, 3'd1);      // R7 memory untouched
        txn(2'd3, 3'd4, 8'd7, 16'h0, 3'd1);
        txn(2'd3, 3'd6, 8'd8, 16'h5555, 3'd1);   // R7 address mismatch
        txn(2'd0, 3'd4, 8'd9, 16'h0, 3'd2);      // R4 linked read in burst
        txn(2'd0, 3'd6, 8'd9, 16'h6666, 3'd1);   // R4 left no reservation
        txn(2'd0, 3'd3, 8'd9, 16'h0, 3'd4);      // R4 no lock taken
        txn(2'd2, 3'd2, 8'd9, 16'h0, 3'd1);
        txn(2'd0, 3'd0, 8'd0, 16'h0, 3'd1);      // R9 idle
        // Seeded random traffic over four words.
        for (int k = 0; k < 600; k++) begin
            logic [BLEN_W-1:0] bl;
            bl = (($urandom % 5) == 0) ? BLEN_W'(2) : BLEN_W'(1);
            txn(CONN_W'($urandom % NCONN), 3'($urandom % 8),
                ADDR_W'($urandom % 4), DATA_W'($urandom), bl);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule